// File: doc/BRIEF.md
# Inline SECDED Memory Error-Code Stage

This block sits between a memory controller front end and the DRAM data path and handles the error code for 64-bit data words. On the write side every 64-bit word is widened to 72 bits: the eight data bytes pass through unchanged and a check byte is appended. The check byte holds seven Hamming check bits and, in its top bit, an overall parity bit.

On the read side each 72-bit word is checked again. The stage recomputes the Hamming syndrome and the overall parity, then sorts the word into one of four classes: clean, parity-bit-only error, single error or double error. It hands on only the 64 data bits and never corrects them. A one-cycle error flag comes out together with each faulty word, along with that word's position inside its burst.

Both paths are independent valid/ready streams with one register stage each. A burst ends with the word that carries `last`.

Top module: `secded_stream_stage`

## Requirements
- R1: On the write path `wr_out_data[63:0]` equals the accepted `wr_in_data` unchanged, and `wr_out_data[71:64]` is the check byte.
- R2: Check byte bit i (i = 0..6) is the XOR of every data bit whose codeword position has bit i set. Positions 1..71 are counted from 1, with check bits at the powers of two. Data bit 0 sits at position 3 and the remaining data bits fill the other non-power-of-two positions in ascending order.
- R3: Check byte bit 7 is the XOR of all 64 data bits and check bits 0..6, so every 72-bit write word has even parity.
- R4: On the read path `rd_out_data` equals `rd_in_data[63:0]` of the same word, unchanged even when an error is flagged. The check byte is dropped.
- R5: A read word with even overall parity and a zero syndrome raises no error flag.
- R6: A read word with odd overall parity and a zero syndrome raises `err_parity`.
- R7: A read word with odd overall parity and a nonzero syndrome raises `err_single`.
- R8: A read word with even overall parity and a nonzero syndrome raises `err_double`.
- R9: At most one error flag is high at a time. A flag is high only in the cycle its read output word is accepted (`rd_out_valid` and `rd_out_ready` both high).
- R10: `err_index` gives the position of the word in its read burst. The first word after reset is 0, and the word after a word with `rd_in_last` is 0.
- R11: Each path has one cycle of latency and can accept one word per cycle. While an output is valid but not ready, its data, `last` and valid stay stable, and no word is lost or repeated. `last` travels with its word.
- R12: While `rst_n` is low at a clock edge, both output valids and all error flags are cleared and the burst index returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_in_valid | input | 1 | Write data word offered |
| wr_in_ready | output | 1 | Write stage can take a word |
| wr_in_data | input | 64 | Write data word |
| wr_in_last | input | 1 | Final word of the write burst |
| wr_out_valid | output | 1 | Encoded word offered |
| wr_out_ready | input | 1 | Downstream takes the encoded word |
| wr_out_data | output | 72 | Data in [63:0], check byte in [71:64] |
| wr_out_last | output | 1 | Final word of the write burst |
| rd_in_valid | input | 1 | Stored 72-bit word offered |
| rd_in_ready | output | 1 | Read stage can take a word |
| rd_in_data | input | 72 | Stored word, same layout as the write output |
| rd_in_last | input | 1 | Final word of the read burst |
| rd_out_valid | output | 1 | Read data word offered |
| rd_out_ready | input | 1 | Upstream takes the read word |
| rd_out_data | output | 64 | Read data bits, uncorrected |
| rd_out_last | output | 1 | Final word of the read burst |
| err_parity | output | 1 | Parity-bit-only error on the accepted word |
| err_single | output | 1 | Single error on the accepted word |
| err_double | output | 1 | Double error on the accepted word |
| err_index | output | 8 | Position of the accepted word in its burst |

## Verification
Correct encodings never produce the hard cases here: a parity-only fault and a double fault that includes the parity bit itself. Both occur only when particular stored bits are flipped on the read side. The bench therefore builds read words with its own encoder and then flips nothing, bit 71 alone, one bit among 0..70, or two distinct bits anywhere among the 72. For each case it predicts the class from the number and place of the flips, not from a syndrome. Random back-pressure on both outputs holds flagged words in the register for several cycles, which shows that a flag appears only in the cycle its word is accepted and that the burst index survives the stall.

// File: rtl/secded_pkg.sv
// Package: shared code geometry and the Hamming check-bit function.
// Assumes a 64-bit data word, seven Hamming bits and one overall parity bit.
package secded_pkg;

    localparam int DATA_W  = 64;
    localparam int HAM_W   = 7;
    localparam int CHK_W   = HAM_W + 1;
    localparam int CODE_W  = DATA_W + CHK_W;
    localparam int POS_MAX = DATA_W + HAM_W;

    // Hamming check bits: data fills the non-power-of-two positions 3,5,6,7,...
    function automatic logic [HAM_W-1:0] ham_checks(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= POS_MAX; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int i = 0; i < HAM_W; i++) begin
                    if (p[i]) c[i] = c[i] ^ d[k];
                end
                k++;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
// Module: secded_encoder
// Builds the check byte for one data word: seven Hamming bits in [6:0] and
// overall parity in [7]. Purely combinational; the caller registers it.
module secded_encoder
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    logic [HAM_W-1:0] ham;

    // Hamming bits from the data, then the parity that makes the word even.
    always_comb begin
        ham   = ham_checks(data_i);
        chk_o = {(^data_i) ^ (^ham), ham};
    end

endmodule

// File: rtl/secded_checker.sv
// Module: secded_checker
// Classifies one stored 72-bit word as clean, parity-only, single or double
// error. Detects only; no correction. Combinational.
module secded_checker
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] word_i,
    output logic              par_err_o,
    output logic              single_o,
    output logic              double_o
);

    logic [HAM_W-1:0] syndrome;
    logic             odd;

    // Syndrome compares stored Hamming bits with recomputed ones; parity over all 72.
    always_comb begin
        syndrome  = ham_checks(word_i[DATA_W-1:0]) ^ word_i[DATA_W +: HAM_W];
        odd       = ^word_i;
        par_err_o = odd  && (syndrome == '0);
        single_o  = odd  && (syndrome != '0);
        double_o  = !odd && (syndrome != '0);
    end

endmodule

// File: rtl/secded_pipe_reg.sv
// Module: secded_pipe_reg
// One-entry valid/ready register stage. Full throughput: it refills in the
// same cycle it drains. Assumes the consumer honours the handshake.
module secded_pipe_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    logic             valid_q;
    logic [WIDTH-1:0] data_q;

    // Space exists when empty or when the held word leaves this cycle.
    assign in_ready  = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_data  = data_q;

    // Load on an input handshake, clear valid on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            if (in_ready) valid_q <= in_valid;
            if (in_valid && in_ready) data_q <= in_data;
        end
    end

    // R11: a stalled word stays put.
    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R11: an accepted input is what appears next.
    assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

    // R12: reset empties the stage.
    assert_reset_empty_R12: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: rtl/secded_stream_stage.sv
// Module: secded_stream_stage
// Inline SECDED stage: the write path appends a check byte to each 64-bit
// word; the read path classifies stored words and strips the check byte.
// Each path has one register stage. Flags are qualified by the read handshake.
module secded_stream_stage
    import secded_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_in_valid,
    output logic              wr_in_ready,
    input  logic [DATA_W-1:0] wr_in_data,
    input  logic              wr_in_last,
    output logic              wr_out_valid,
    input  logic              wr_out_ready,
    output logic [CODE_W-1:0] wr_out_data,
    output logic              wr_out_last,
    input  logic              rd_in_valid,
    output logic              rd_in_ready,
    input  logic [CODE_W-1:0] rd_in_data,
    input  logic              rd_in_last,
    output logic              rd_out_valid,
    input  logic              rd_out_ready,
    output logic [DATA_W-1:0] rd_out_data,
    output logic              rd_out_last,
    output logic              err_parity,
    output logic              err_single,
    output logic              err_double,
    output logic [IDX_W-1:0]  err_index
);

    localparam int WR_W = 1 + CODE_W;
    localparam int RD_W = 1 + IDX_W + 3 + DATA_W;

    // ---------------- write path ----------------
    logic [CHK_W-1:0] wr_chk;
    logic [WR_W-1:0]  wr_pay_in, wr_pay_out;

    secded_encoder enc_i (.data_i(wr_in_data), .chk_o(wr_chk));

    assign wr_pay_in = {wr_in_last, wr_chk, wr_in_data};

    secded_pipe_reg #(.WIDTH(WR_W)) wr_reg_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(wr_in_valid), .in_ready(wr_in_ready), .in_data(wr_pay_in),
        .out_valid(wr_out_valid), .out_ready(wr_out_ready), .out_data(wr_pay_out)
    );

    assign wr_out_last = wr_pay_out[WR_W-1];
    assign wr_out_data = wr_pay_out[CODE_W-1:0];

    // ---------------- read path ----------------
    logic             chk_par, chk_single, chk_double;
    logic [IDX_W-1:0] idx_q;
    logic             rd_in_fire;
    logic [RD_W-1:0]  rd_pay_in, rd_pay_out;
    logic             fl_par, fl_single, fl_double, rd_out_fire;

    secded_checker chk_i (
        .word_i(rd_in_data), .par_err_o(chk_par),
        .single_o(chk_single), .double_o(chk_double)
    );

    assign rd_in_fire = rd_in_valid && rd_in_ready;

    // Burst position counter: steps per accepted word, wraps to 0 after last.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx_q <= '0;
        else if (rd_in_fire) idx_q <= rd_in_last ? '0 : idx_q + 1'b1;
    end

    assign rd_pay_in = {rd_in_last, idx_q, chk_par, chk_single, chk_double,
                        rd_in_data[DATA_W-1:0]};

    secded_pipe_reg #(.WIDTH(RD_W)) rd_reg_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rd_in_valid), .in_ready(rd_in_ready), .in_data(rd_pay_in),
        .out_valid(rd_out_valid), .out_ready(rd_out_ready), .out_data(rd_pay_out)
    );

    // Unpack the read register and gate flags by the output handshake.
    always_comb begin
        rd_out_last = rd_pay_out[RD_W-1];
        err_index   = rd_pay_out[DATA_W+3 +: IDX_W];
        fl_par      = rd_pay_out[DATA_W+2];
        fl_single   = rd_pay_out[DATA_W+1];
        fl_double   = rd_pay_out[DATA_W];
        rd_out_data = rd_pay_out[DATA_W-1:0];
        rd_out_fire = rd_out_valid && rd_out_ready;
        err_parity  = rd_out_fire && fl_par;
        err_single  = rd_out_fire && fl_single;
        err_double  = rd_out_fire && fl_double;
    end

    // R3: every encoded word carries even parity.
    assert_even_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out_valid |-> (^wr_out_data) == 1'b0);

    // R1: data bytes leave the write path untouched.
    assert_wr_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_in_valid && wr_in_ready) |=> wr_out_data[DATA_W-1:0] == $past(wr_in_data));

    // R4: read data is forwarded without correction.
    assert_rd_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_in_fire |=> rd_out_data == $past(rd_in_data[DATA_W-1:0]));

    // R9: classes are mutually exclusive in the held word.
    assert_one_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out_valid |-> $onehot0({fl_par, fl_single, fl_double}));

    // R10: after a last word the next burst starts at index 0.
    assert_index_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_in_fire && rd_in_last) |=> idx_q == '0);

endmodule

// File: tb/secded_stream_stage_tb_top.sv
// Bench: behavioural model with queues, checked every cycle at the falling edge.
module secded_stream_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_in_valid = 1'b0, wr_in_last = 1'b0, wr_out_ready = 1'b0;
    logic [63:0] wr_in_data = '0;
    logic        wr_in_ready, wr_out_valid, wr_out_last;
    logic [71:0] wr_out_data;
    logic        rd_in_valid = 1'b0, rd_in_last = 1'b0, rd_out_ready = 1'b0;
    logic [71:0] rd_in_data = '0;
    logic        rd_in_ready, rd_out_valid, rd_out_last;
    logic [63:0] rd_out_data;
    logic        err_parity, err_single, err_double;
    logic [7:0]  err_index;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    secded_stream_stage #(.IDX_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready),
        .wr_in_data(wr_in_data), .wr_in_last(wr_in_last),
        .wr_out_valid(wr_out_valid), .wr_out_ready(wr_out_ready),
        .wr_out_data(wr_out_data), .wr_out_last(wr_out_last),
        .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready),
        .rd_in_data(rd_in_data), .rd_in_last(rd_in_last),
        .rd_out_valid(rd_out_valid), .rd_out_ready(rd_out_ready),
        .rd_out_data(rd_out_data), .rd_out_last(rd_out_last),
        .err_parity(err_parity), .err_single(err_single),
        .err_double(err_double), .err_index(err_index)
    );

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference encoder: XOR of the positions of set data bits gives the check bits.
    function automatic logic [71:0] ref_enc(input logic [63:0] d);
        logic [6:0] syn;
        int k;
        syn = '0;
        k = 0;
        for (int pos = 1; pos <= 71; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (d[k]) syn = syn ^ pos[6:0];
                k++;
            end
        end
        return {(^d) ^ (^syn), syn, d};
    endfunction

    logic [71:0] wq[$];
    logic        wq_last[$];
    logic [63:0] rq_data[$];
    int          rq_kind[$];
    int          rq_idx[$];
    logic        rq_last[$];

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic        wr_acc, rd_acc;
        int          kind, cur_kind, model_idx;
        logic [71:0] word, ew;
        logic [2:0]  exp_fl;
        wr_acc = 1'b1;
        rd_acc = 1'b1;
        cur_kind = 0;
        model_idx = 0;

        repeat (4) @(negedge clk);
        // R12: reset state.
        check("R12 wr_out_valid", {71'd0, wr_out_valid}, 72'd0);
        check("R12 rd_out_valid", {71'd0, rd_out_valid}, 72'd0);
        check("R12 flags", {69'd0, err_parity, err_single, err_double}, 72'd0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            if (wr_acc || !wr_in_valid) begin
                wr_in_valid = ($urandom % 4) != 0;
                wr_in_data  = {$urandom, $urandom};
                wr_in_last  = ($urandom % 3) == 0;
            end
            if (rd_acc || !rd_in_valid) begin
                rd_in_valid = ($urandom % 4) != 0;
                kind = $urandom % 4;
                word = ref_enc({$urandom, $urandom});
                if (kind == 1) word[71] = ~word[71];
                else if (kind == 2) begin
                    int b; b = $urandom % 71; word[b] = ~word[b];
                end else if (kind == 3) begin
                    int b1, b2;
                    b1 = $urandom % 72;
                    b2 = (b1 + 1 + ($urandom % 71)) % 72;
                    word[b1] = ~word[b1];
                    word[b2] = ~word[b2];
                end
                cur_kind   = kind;
                rd_in_data = word;
                rd_in_last = ($urandom % 4) == 0;
            end
            wr_out_ready = ($urandom % 4) != 0;
            rd_out_ready = ($urandom % 3) != 0;
            #1;
            // Write output side first, then model the accepted input.
            if (wr_out_valid && wr_out_ready) begin
                if (wq.size() == 0) check("R11 write word without input", 72'd1, 72'd0);
                else begin
                    ew = wq.pop_front();
                    check("R1 write data", {8'd0, wr_out_data[63:0]}, {8'd0, ew[63:0]});
                    check("R2 hamming bits", {65'd0, wr_out_data[70:64]}, {65'd0, ew[70:64]});
                    check("R3 parity bit", {71'd0, wr_out_data[71]}, {71'd0, ew[71]});
                    check("R11 write last", {71'd0, wr_out_last}, {71'd0, wq_last.pop_front()});
                end
            end
            wr_acc = wr_in_valid && wr_in_ready;
            if (wr_acc) begin
                wq.push_back(ref_enc(wr_in_data));
                wq_last.push_back(wr_in_last);
            end
            if (rd_out_valid && rd_out_ready) begin
                if (rq_data.size() == 0) check("R11 read word without input", 72'd1, 72'd0);
                else begin
                    kind = rq_kind.pop_front();
                    exp_fl = (kind == 1) ? 3'b100 : (kind == 2) ? 3'b010 :
                             (kind == 3) ? 3'b001 : 3'b000;
                    check("R4 read data", {8'd0, rd_out_data}, {8'd0, rq_data.pop_front()});
                    check(kind == 0 ? "R5 clean" : kind == 1 ? "R6 parity only" :
                          kind == 2 ? "R7 single" : "R8 double",
                          {69'd0, err_parity, err_single, err_double}, {69'd0, exp_fl});
                    check("R10 index", {64'd0, err_index}, {64'd0, 8'(rq_idx.pop_front())});
                    check("R11 read last", {71'd0, rd_out_last}, {71'd0, rq_last.pop_front()});
                end
            end else begin
                check("R9 flags without handshake",
                      {69'd0, err_parity, err_single, err_double}, 72'd0);
            end
            rd_acc = rd_in_valid && rd_in_ready;
            if (rd_acc) begin
                rq_data.push_back(rd_in_data[63:0]);
                rq_kind.push_back(cur_kind);
                rq_idx.push_back(model_idx);
                rq_last.push_back(rd_in_last);
                model_idx = rd_in_last ? 0 : model_idx + 1;
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule